// File: doc/BRIEF.md
# Pluggable Module Power-Down and Reset Sequencer

This block sequences the power state and reset of a pluggable optical module. One host input does two jobs: held high it keeps the module in a low-power standby, and its falling edge launches a full module reset of a fixed length. The input is asynchronous, so it passes through a two-flop synchroniser before the level and edge are used. A reset also runs after power-on. If the host input is already high at power-on, that reset runs with the module already in standby.

While a reset is running or the module is powered down, the raw loss-of-signal and not-ready indications are not trusted. Both qualified outputs are then forced to their "bad" value, and the loss alarm flag cannot set. When a reset ends, the block first spends one cycle presenting valid status with the interrupt idle. On the next edge it latches a reset-complete flag, which pulls the active-low interrupt line. The host clears the flags by writing ones to a status address on a simple register write port. Leaving standby produces a falling edge, so it starts a second reset and a second completion interrupt.

Top module: `pwrdn_rst_seq`

## Requirements
- R1: While `rst_n` is low, `core_rst` is 1, `low_pwr_en` is 0, `irq_n` is 1, and `sig_loss_q` and `not_rdy_q` are both 1.
- R2: `low_pwr_en` follows `pd_hold_in` two clock edges after the input changes, through a two-flop synchroniser. While the synchronised input or its previous sample is high, `sig_loss_q` and `not_rdy_q` are forced to 1.
- R3: After `rst_n` is released, `core_rst` stays high for exactly INIT_CYC cycles. A single completion cycle follows, and then the reset-complete flag sets and `irq_n` goes low. This also happens when `pd_hold_in` is high, and then `low_pwr_en` is already 1.
- R4: While `core_rst` is high, `sig_loss_q` and `not_rdy_q` read 1, and the loss alarm flag is cleared and cannot set.
- R5: In the completion cycle (`core_rst` low, with power-down released), `sig_loss_q` and `not_rdy_q` equal their raw inputs and `irq_n` is still 1. The reset-complete flag sets only on the following edge.
- R6: Writing a word with bit 0 = 1 to address 84 clears the reset-complete flag, and `irq_n` returns high in the next cycle. A write to another address, or with bit 0 = 0, leaves the flag set.
- R7: A falling edge of `pd_hold_in` makes `core_rst` rise on the third clock edge after the change. `core_rst` then lasts INIT_CYC cycles and is followed by another reset-complete interrupt.
- R8: `irq_n` is low only when the reset-complete flag (status bit 0) is set, or when the loss alarm flag (status bit 1) is set while status is valid. The loss alarm sets when status is valid and `sig_loss_raw` is 1, and it is cleared by writing bit 1 = 1 to address 84.
- R9: A falling edge that arrives while a reset is running reloads the counter, so `core_rst` lasts INIT_CYC cycles from the new start. Only one completion interrupt is posted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| pd_hold_in | input | 1 | Host power-down level / reset edge, asynchronous |
| sig_loss_raw | input | 1 | Unqualified loss-of-signal indication |
| not_rdy_raw | input | 1 | Unqualified not-ready indication |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data, ones clear flags |
| low_pwr_en | output | 1 | Standby mode enable |
| core_rst | output | 1 | Internal module reset, high during initialisation |
| sig_loss_q | output | 1 | Qualified loss-of-signal, 1 when invalid |
| not_rdy_q | output | 1 | Qualified not-ready, 1 when invalid |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The synchroniser gives `low_pwr_en` two cycles of latency. `core_rst` rises three cycles after a falling input and stays high for INIT_CYC cycles. After that there is one completion cycle with valid status, and `irq_n` falls on the cycle after it. A flag write is seen on `irq_n` one cycle after the strobe. The bench computes each due cycle from these latencies, counting from the cycle in which it drives a stimulus. It queues every expectation with its due cycle, and the monitor compares at the falling clock edge of exactly that cycle. Inputs change just after that edge, so no comparison races a stimulus.

// File: rtl/pwrdn_rst_seq_pkg.sv
package pwrdn_rst_seq_pkg;

  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_POST = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_t;

  // Counter width needed to hold values up to cycles-1.
  function automatic int cnt_width(input int cycles);
    return (cycles > 2) ? $clog2(cycles) : 1;
  endfunction

  // Reload value: INIT spans 'cycles' cycles counting down to zero.
  function automatic int init_last(input int cycles);
    return cycles - 1;
  endfunction

endpackage

// File: rtl/pwrdn_rst_seq_sync.sv
module pwrdn_rst_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic lvl_prev,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              prev_q;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain[STAGES-1];
  end

  assign lvl      = chain[STAGES-1];
  assign lvl_prev = prev_q;
  assign fall     = prev_q & ~chain[STAGES-1];

endmodule

// File: rtl/pwrdn_rst_seq_timer.sv
module pwrdn_rst_seq_timer
  import pwrdn_rst_seq_pkg::*;
#(
  parameter int INIT_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_evt,
  output logic core_rst,
  output logic post_evt,
  output logic done_evt
);

  localparam int CNT_W = cnt_width(INIT_CYC);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(init_last(INIT_CYC));

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_INIT;
      cnt   <= LAST;
    end else if (fall_evt) begin
      state <= ST_INIT;
      cnt   <= LAST;
    end else begin
      case (state)
        ST_INIT: begin
          if (cnt == '0) state <= ST_POST;
          else           cnt   <= cnt - 1'b1;
        end
        ST_POST: state <= ST_RUN;
        default: state <= ST_RUN;
      endcase
    end
  end

  assign core_rst = (state == ST_INIT);
  assign post_evt = (state == ST_POST);
  assign done_evt = (state == ST_INIT) && (cnt == '0);

endmodule

// File: rtl/pwrdn_rst_seq_flags.sv
module pwrdn_rst_seq_flags #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int STAT_ADDR = 84
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_rst,
  input  logic              post_evt,
  input  logic              valid,
  input  logic              sig_loss_raw,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rc_flag,
  output logic              los_flag,
  output logic              irq_n
);

  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic hit, clr_rc, clr_los;

  assign hit     = wr_en && (wr_addr == STAT_A);
  assign clr_rc  = hit && wr_data[0];
  assign clr_los = hit && wr_data[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rc_flag <= 1'b0;
    else if (post_evt) rc_flag <= 1'b1;
    else if (clr_rc)   rc_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     los_flag <= 1'b0;
    else if (core_rst)              los_flag <= 1'b0;
    else if (valid && sig_loss_raw) los_flag <= 1'b1;
    else if (clr_los)               los_flag <= 1'b0;
  end

  assign irq_n = ~(rc_flag | (los_flag & valid));

endmodule

// File: rtl/pwrdn_rst_seq.sv
module pwrdn_rst_seq #(
  parameter int INIT_CYC    = 1000,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int STAT_ADDR   = 84
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_hold_in,
  input  logic              sig_loss_raw,
  input  logic              not_rdy_raw,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              low_pwr_en,
  output logic              core_rst,
  output logic              sig_loss_q,
  output logic              not_rdy_q,
  output logic              irq_n
);

  // Named internal events, visible to the bound checker.
  logic hold_lvl, hold_prev, fall_evt;
  logic post_evt, done_evt;
  logic valid;
  logic rc_flag, los_flag;

  pwrdn_rst_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (pd_hold_in),
    .lvl      (hold_lvl),
    .lvl_prev (hold_prev),
    .fall     (fall_evt)
  );

  pwrdn_rst_seq_timer #(.INIT_CYC(INIT_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_evt (fall_evt),
    .core_rst (core_rst),
    .post_evt (post_evt),
    .done_evt (done_evt)
  );

  // Status is trusted only outside reset and after the hold has been low two samples.
  assign valid = ~core_rst & ~hold_lvl & ~hold_prev;

  pwrdn_rst_seq_flags #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .STAT_ADDR (STAT_ADDR)
  ) u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_rst     (core_rst),
    .post_evt     (post_evt),
    .valid        (valid),
    .sig_loss_raw (sig_loss_raw),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .rc_flag      (rc_flag),
    .los_flag     (los_flag),
    .irq_n        (irq_n)
  );

  assign low_pwr_en = hold_lvl;
  assign sig_loss_q = valid ? sig_loss_raw : 1'b1;
  assign not_rdy_q  = valid ? not_rdy_raw  : 1'b1;

endmodule

// File: rtl/pwrdn_rst_seq_chk.sv
module pwrdn_rst_seq_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int STAT_ADDR = 84
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              core_rst,
  input logic              sig_loss_q,
  input logic              not_rdy_q,
  input logic              irq_n,
  input logic              fall_evt,
  input logic              post_evt,
  input logic              valid,
  input logic              rc_flag,
  input logic              los_flag
);

  // R3
  rc_from_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rc_flag) |-> $past(post_evt));

  // R5
  rc_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rc_flag) |-> !$past(core_rst));

  // R4
  status_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (sig_loss_q && not_rdy_q));

  // R4
  los_cleared_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> !los_flag);

  // R9
  restart_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> (core_rst && !post_evt));

  // R6
  rc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(STAT_ADDR) && wr_data[0] && !post_evt) |=> !rc_flag);

  // R8
  no_spurious_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rc_flag && !los_flag) |-> irq_n);

endmodule

bind pwrdn_rst_seq pwrdn_rst_seq_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .STAT_ADDR (STAT_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .core_rst   (core_rst),
  .sig_loss_q (sig_loss_q),
  .not_rdy_q  (not_rdy_q),
  .irq_n      (irq_n),
  .fall_evt   (fall_evt),
  .post_evt   (post_evt),
  .valid      (valid),
  .rc_flag    (rc_flag),
  .los_flag   (los_flag)
);

// File: tb/pwrdn_rst_seq_bench.sv
`timescale 1ns/1ps
module pwrdn_rst_seq_bench;

  localparam int N = 8;

  // Observed bit order: {core_rst, low_pwr_en, irq_n, sig_loss_q, not_rdy_q}
  localparam logic [4:0] C_RST = 5'b10000;
  localparam logic [4:0] C_LP  = 5'b01000;
  localparam logic [4:0] C_IRQ = 5'b00100;
  localparam logic [4:0] C_LOS = 5'b00010;
  localparam logic [4:0] C_NR  = 5'b00001;
  localparam logic [4:0] C_ALL = 5'b11111;

  typedef struct {
    int         due;
    string      tag;
    logic [4:0] care;
    logic [4:0] val;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pd_hold_in = 1'b1;
  logic       sig_loss_raw = 1'b0;
  logic       not_rdy_raw = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = 8'd0;
  logic [7:0] wr_data = 8'd0;
  logic       low_pwr_en, core_rst, sig_loss_q, not_rdy_q, irq_n;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  exp_t sb[$];

  always #2 clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  pwrdn_rst_seq #(.INIT_CYC(N)) u_pwrdn_rst_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .pd_hold_in   (pd_hold_in),
    .sig_loss_raw (sig_loss_raw),
    .not_rdy_raw  (not_rdy_raw),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .low_pwr_en   (low_pwr_en),
    .core_rst     (core_rst),
    .sig_loss_q   (sig_loss_q),
    .not_rdy_q    (not_rdy_q),
    .irq_n        (irq_n)
  );

  task automatic expect_at(input int due, input string tag,
                           input logic [4:0] care, input logic [4:0] val);
    exp_t e;
    e.due = due; e.tag = tag; e.care = care; e.val = val;
    sb.push_back(e);
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
  endtask

  // Monitor: compare due items at the falling edge of their cycle.
  always @(negedge clk) begin
    logic [4:0] obs;
    obs = {core_rst, low_pwr_en, irq_n, sig_loss_q, not_rdy_q};
    while (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if ((obs & e.care) !== (e.val & e.care)) begin
        errors++;
        $display("FAIL %s cyc %0d: got %b expected %b (care %b)",
                 e.tag, cyc, obs, e.val, e.care);
      end
    end
  end

  // Driver: expectations from the requirements, then stimulus per cycle.
  initial begin
    expect_at(0,  "R1", C_ALL, 5'b10111);
    expect_at(2,  "R3", C_RST | C_LP, 5'b11000);
    expect_at(7,  "R4", C_RST | C_LOS | C_NR, 5'b10011);
    expect_at(8,  "R3", C_RST | C_IRQ | C_LOS, 5'b00110);
    expect_at(9,  "R3", C_IRQ, 5'b00000);
    expect_at(12, "R3", C_IRQ, 5'b00000);
    expect_at(13, "R6", C_IRQ, 5'b00100);
    expect_at(16, "R8", C_IRQ | C_LOS, 5'b00110);
    expect_at(19, "R2", C_LP, 5'b01000);
    expect_at(20, "R2", C_LP | C_LOS, 5'b00010);
    expect_at(21, "R7", C_RST, 5'b10000);
    expect_at(28, "R4", C_RST | C_LOS | C_NR, 5'b10011);
    expect_at(29, "R5", C_ALL, 5'b00100);
    expect_at(30, "R7", C_IRQ, 5'b00000);
    expect_at(33, "R6", C_IRQ, 5'b00100);
    expect_at(36, "R8", C_IRQ | C_LOS, 5'b00010);
    expect_at(39, "R8", C_IRQ, 5'b00100);
    expect_at(42, "R2", C_LP | C_LOS | C_NR, 5'b01011);
    expect_at(47, "R7", C_RST, 5'b10000);
    expect_at(55, "R9", C_RST | C_IRQ, 5'b10100);
    expect_at(60, "R9", C_RST, 5'b10000);
    expect_at(61, "R9", C_RST | C_IRQ, 5'b00100);
    expect_at(62, "R9", C_IRQ, 5'b00000);
    expect_at(64, "R6", C_IRQ, 5'b00000);
    expect_at(65, "R6", C_IRQ, 5'b00000);
    expect_at(67, "R6", C_IRQ, 5'b00100);
    expect_at(75, "R9", C_IRQ, 5'b00100);

    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    forever begin
      @(negedge clk);
      #1;
      wr_en = 1'b0;
      case (cyc)
        10: sig_loss_raw = 1'b1;
        12: reg_write(8'd84, 8'h01);
        16: sig_loss_raw = 1'b0;
        18: pd_hold_in = 1'b0;
        32: reg_write(8'd84, 8'h01);
        35: sig_loss_raw = 1'b1;
        37: sig_loss_raw = 1'b0;
        38: reg_write(8'd84, 8'h02);
        40: pd_hold_in = 1'b1;
        44: pd_hold_in = 1'b0;
        48: pd_hold_in = 1'b1;
        50: pd_hold_in = 1'b0;
        63: reg_write(8'd85, 8'h01);
        64: reg_write(8'd84, 8'h02);
        66: reg_write(8'd84, 8'h01);
        80: begin
          if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
          end
          $display("CHECKS %0d ERRORS %0d", checks, errors);
          $finish;
        end
        default: ;
      endcase
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: cycle %0d reached, expected end at 80", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule